// File: doc/BRIEF.md
# Binary and Decimal Add-Subtract Unit with Condition Flags

This block is the arithmetic unit for one byte. It adds with carry and subtracts with borrow. It can also increment or decrement the memory operand by one. The incoming carry always enters an add. In a subtract the same bit acts as an inverted borrow: a 1 means "no borrow". When the decimal input is high, add and subtract treat both operands as packed two-digit BCD. Each digit is corrected inside the same operation, so no separate adjust step is needed. Increment and decrement stay binary whatever the decimal input says.

A valid strobe loads the result and the carry, zero, negative and overflow flags into output registers. While the strobe is low, the registers keep their values. The surrounding datapath supplies the accumulator, the memory operand, the current carry and the decimal mode bit. It takes the registered result and flags back.

Top module: `addsub_flags_unit`

## Requirements
- R1: After an active-low asynchronous reset, the result and all four flags are 0. In a cycle where valid_i is low, the result and all four flags hold their previous values.
- R2: With op_i = 2'b00 (add) and dec_i = 0, the next result is (acc_i + mem_i + carry_i) mod 256. Carry is set exactly when that sum exceeds 255.
- R3: With op_i = 2'b01 (subtract) and dec_i = 0, the next result is (acc_i - mem_i - (1 - carry_i)) mod 256. Carry is 1 when no borrow occurred, meaning acc_i >= mem_i + 1 - carry_i, and 0 otherwise.
- R4: In binary add and subtract, overflow is set exactly when the signed two's-complement result of the same operation falls outside -128..127. For example, two operands with differing signs never overflow an add.
- R5: After any binary add or subtract, and after every increment or decrement, the zero flag is 1 exactly when the result is 0. The negative flag equals result bit 7.
- R6: With op_i = 2'b00 and dec_i = 1, valid packed BCD operands (high digit in bits 7:4) give the BCD form of (A + M + carry_i) mod 100. Carry is set exactly when that decimal sum exceeds 99.
- R7: With op_i = 2'b01 and dec_i = 1, valid packed BCD operands give the BCD form of (A - M - (1 - carry_i)) mod 100. Carry is set exactly when no decimal borrow occurred.
- R8: op_i = 2'b10 gives (mem_i + 1) mod 256 and op_i = 2'b11 gives (mem_i - 1) mod 256. Both are binary, and dec_i and carry_i have no effect on them.
- R9: Increment and decrement leave the carry and overflow outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load strobe for result and flags |
| op_i | input | 2 | 00 add, 01 subtract, 10 increment, 11 decrement |
| acc_i | input | W | Accumulator operand |
| mem_i | input | W | Memory operand (sole operand of inc/dec) |
| carry_i | input | 1 | Carry in / inverted borrow in |
| dec_i | input | 1 | Decimal mode for add and subtract |
| result_o | output | W | Registered result |
| carry_o | output | 1 | Registered carry |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
The hardest cases to reach are the decimal corrections that ripple through both digits. Examples are 99 + 1 producing 00 with a carry out, and 00 - 01 wrapping to 99 with a borrow. In both, the low-digit fix-up feeds the high-digit fix-up, which then decides the carry. Random bytes almost never form valid BCD, so the stimulus builds decimal operands from random digits and also applies these ripple cases as directed vectors. A second hard case is an increment issued while the decimal input is high. For example, 09 must become 0A and not 10, so the directed list includes it. That list also interleaves increments after carry-producing adds, so that an unchanged carry can be seen on the outputs.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_INC = 2'b10,
    OP_DEC = 2'b11
  } op_e;
endpackage

// File: rtl/bin_addsub.sv
module bin_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  input  logic         sub_i,
  output logic [W-1:0] s_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   tot;

  // subtract = a + ~b + c, carry acts as inverted borrow
  assign b_eff = sub_i ? ~b_i : b_i;
  assign tot   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_i};
  assign s_o   = tot[W-1:0];
  assign c_o   = tot[W];
  assign v_o   = (a_i[W-1] == b_eff[W-1]) && (tot[W-1] != a_i[W-1]);
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       c_i,   // add: carry in, sub: borrow in
  input  logic       sub_i,
  output logic [3:0] d_o,
  output logic       c_o    // add: carry out, sub: borrow out
);
  logic [4:0] raw_add, raw_sub;
  logic [3:0] adj_add, adj_sub;
  logic       fix_add, fix_sub;

  assign raw_add = {1'b0, a_i} + {1'b0, b_i} + {4'd0, c_i};
  assign raw_sub = {1'b0, a_i} - {1'b0, b_i} - {4'd0, c_i};
  assign fix_add = raw_add > 5'd9;
  assign fix_sub = raw_sub[4];
  assign adj_add = raw_add[3:0] + 4'd6;
  assign adj_sub = raw_sub[3:0] - 4'd6;

  always_comb begin
    if (sub_i) begin
      d_o = fix_sub ? adj_sub : raw_sub[3:0];
      c_o = fix_sub;
    end else begin
      d_o = fix_add ? adj_add : raw_add[3:0];
      c_o = fix_add;
    end
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,   // carry / inverted borrow
  input  logic         sub_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  localparam int ND = W / 4;

  logic [ND:0] chain;

  assign chain[0] = sub_i ? ~c_i : c_i;

  for (genvar g = 0; g < ND; g++) begin : g_dig
    bcd_digit u_dig (
      .a_i   (a_i[4*g +: 4]),
      .b_i   (b_i[4*g +: 4]),
      .c_i   (chain[g]),
      .sub_i (sub_i),
      .d_o   (s_o[4*g +: 4]),
      .c_o   (chain[g+1])
    );
  end

  assign c_o = sub_i ? ~chain[ND] : chain[ND];
endmodule

// File: rtl/step_unit.sv
module step_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         dn_i,
  output logic [W-1:0] r_o
);
  assign r_o = dn_i ? a_i - W'(1) : a_i + W'(1);
endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mem_i,
  input  logic         carry_i,
  input  logic         dec_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o
);
  logic         is_sub;
  logic [W-1:0] bin_s, bcd_s, step_r, nxt_res;
  logic         bin_c, bin_v, bcd_c, nxt_c, nxt_v;

  assign is_sub = (op_i == OP_SUB);

  bin_addsub #(.W(W)) u_bin (
    .a_i (acc_i), .b_i (mem_i), .c_i (carry_i), .sub_i (is_sub),
    .s_o (bin_s), .c_o (bin_c), .v_o (bin_v)
  );

  bcd_addsub #(.W(W)) u_bcd (
    .a_i (acc_i), .b_i (mem_i), .c_i (carry_i), .sub_i (is_sub),
    .s_o (bcd_s), .c_o (bcd_c)
  );

  step_unit #(.W(W)) u_step (
    .a_i (mem_i), .dn_i (op_i == OP_DEC), .r_o (step_r)
  );

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        nxt_res = dec_i ? bcd_s : bin_s;
        nxt_c   = dec_i ? bcd_c : bin_c;
        nxt_v   = bin_v;
      end
      default: begin
        nxt_res = step_r;
        nxt_c   = carry_o;
        nxt_v   = ovf_o;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
      neg_o    <= 1'b0;
      ovf_o    <= 1'b0;
    end else if (valid_i) begin
      result_o <= nxt_res;
      carry_o  <= nxt_c;
      zero_o   <= (nxt_res == '0);
      neg_o    <= nxt_res[W-1];
      ovf_o    <= nxt_v;
    end
  end

  // R1: outputs frozen without strobe
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(carry_o) && $stable(zero_o)
                 && $stable(neg_o) && $stable(ovf_o));

  // R4: mixed-sign add cannot overflow
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !dec_i && op_i == OP_ADD && (acc_i[W-1] != mem_i[W-1]) |=> !ovf_o);

  // R5: zero flag tracks result after binary updates
  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (!dec_i || op_i[1]) |=> zero_o == (result_o == '0));

  // R8: increment is binary regardless of decimal mode
  p_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_INC |=> result_o == $past(mem_i) + W'(1));

  // R9: inc/dec keep carry and overflow
  p_keep_cv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[1] |=> $stable(carry_o) && $stable(ovf_o));
endmodule

// File: tb/sim_addsub_flags_unit.sv
module sim_addsub_flags_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] acc = '0, mem = '0;
  logic       cin = 1'b0, dec = 1'b0;
  logic [7:0] res;
  logic       c_o, z_o, n_o, v_o;

  addsub_flags_unit #(.W(8)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .op_i (op),
    .acc_i (acc), .mem_i (mem), .carry_i (cin), .dec_i (dec),
    .result_o (res), .carry_o (c_o), .zero_o (z_o), .neg_o (n_o), .ovf_o (v_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_tests = 0, n_fail = 0;
  bit    done = 0;
  // reference state
  int    m_res = 0;
  bit    m_c = 0, m_z = 0, m_n = 0, m_v = 0;
  bit    zn_ok = 1, v_ok = 1;
  string t_res = "R1", t_c = "R1", t_v = "R1", t_zn = "R1";

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(t_res, "result", int'(res), m_res);
    chk(t_c, "carry", int'(c_o), int'(m_c));
    if (zn_ok) begin
      chk(t_zn, "zero", int'(z_o), int'(m_z));
      chk(t_zn, "neg", int'(n_o), int'(m_n));
    end
    if (v_ok) chk(t_v, "ovf", int'(v_o), int'(m_v));
  endtask

  function automatic int bcd2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int i2bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  task automatic model(bit v, logic [1:0] o, logic [7:0] a, logic [7:0] m, bit c, bit d);
    int s, sa, sm, sv;
    if (!v) begin
      t_res = "R1"; t_c = "R1"; t_v = "R1"; t_zn = "R1";
      return;
    end
    sa = int'($signed(a));
    sm = int'($signed(m));
    case (o)
      2'b00, 2'b01: begin
        if (d) begin
          if (o == 2'b00) begin
            s = bcd2i(a) + bcd2i(m) + int'(c);
            m_c = s > 99; m_res = i2bcd(s % 100); t_res = "R6"; t_c = "R6";
          end else begin
            s = bcd2i(a) - bcd2i(m) - (1 - int'(c));
            m_c = s >= 0; m_res = i2bcd((s + 100) % 100); t_res = "R7"; t_c = "R7";
          end
          zn_ok = 0; v_ok = 0;
        end else begin
          if (o == 2'b00) begin
            s  = int'(a) + int'(m) + int'(c);
            sv = sa + sm + int'(c);
            m_c = s > 255; t_res = "R2"; t_c = "R2";
          end else begin
            s  = int'(a) - int'(m) - (1 - int'(c));
            sv = sa - sm - (1 - int'(c));
            m_c = s >= 0; t_res = "R3"; t_c = "R3";
          end
          m_res = (s + 256) % 256;
          m_v = (sv > 127) || (sv < -128);
          zn_ok = 1; v_ok = 1; t_v = "R4"; t_zn = "R5";
        end
      end
      default: begin
        m_res = (o == 2'b10) ? (int'(m) + 1) % 256 : (int'(m) + 255) % 256;
        t_res = "R8"; t_c = "R9"; t_v = "R9"; t_zn = "R5";
        zn_ok = 1;
      end
    endcase
    m_z = (m_res == 0);
    m_n = m_res[7];
  endtask

  // called at a falling edge
  task automatic apply(bit v, logic [1:0] o, logic [7:0] a, logic [7:0] m, bit c, bit d);
    valid = v; op = o; acc = a; mem = m; cin = c; dec = d;
    @(posedge clk);
    model(v, o, a, m, c, d);
    @(negedge clk);
    compare();
  endtask

  function automatic logic [7:0] rnd_bcd();
    return {4'($urandom % 10), 4'($urandom % 10)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    compare();                 // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    // R2/R4 binary add corners
    apply(1, 2'b00, 8'h50, 8'h50, 0, 0);
    apply(1, 2'b00, 8'hFF, 8'h01, 0, 0);
    apply(1, 2'b10, 8'h00, 8'h41, 1, 0);   // R9: carry from previous add kept
    apply(1, 2'b00, 8'h7F, 8'h00, 1, 0);
    apply(1, 2'b00, 8'h80, 8'h7F, 1, 0);   // R4 mixed sign
    // R3/R4 binary subtract
    apply(1, 2'b01, 8'h00, 8'h01, 1, 0);
    apply(1, 2'b01, 8'h80, 8'h01, 1, 0);
    apply(1, 2'b01, 8'h05, 8'h05, 0, 0);
    apply(1, 2'b01, 8'h05, 8'h05, 1, 0);
    // R6 decimal add ripple cases
    apply(1, 2'b00, 8'h99, 8'h01, 0, 1);
    apply(1, 2'b00, 8'h58, 8'h46, 1, 1);
    apply(1, 2'b00, 8'h12, 8'h34, 0, 1);
    apply(1, 2'b00, 8'h99, 8'h99, 1, 1);
    // R7 decimal subtract
    apply(1, 2'b01, 8'h00, 8'h01, 1, 1);
    apply(1, 2'b01, 8'h46, 8'h12, 1, 1);
    apply(1, 2'b01, 8'h40, 8'h13, 0, 1);
    apply(1, 2'b01, 8'h10, 8'h10, 0, 1);
    // R8 inc/dec binary even with decimal set
    apply(1, 2'b10, 8'h00, 8'h09, 1, 1);
    apply(1, 2'b10, 8'h00, 8'hFF, 0, 1);
    apply(1, 2'b11, 8'h00, 8'h00, 1, 0);
    apply(1, 2'b11, 8'h00, 8'h10, 0, 1);
    // R1 hold with changing inputs
    apply(0, 2'b00, 8'hFF, 8'hFF, 1, 0);
    apply(0, 2'b01, 8'h12, 8'h34, 0, 1);
    for (int i = 0; i < 2000; i++) begin
      bit d = ($urandom % 3) == 0;
      bit v = ($urandom % 5) != 0;
      logic [1:0] o = 2'($urandom % 4);
      logic [7:0] a = d ? rnd_bcd() : 8'($urandom);
      logic [7:0] m = d ? rnd_bcd() : 8'($urandom);
      apply(v, o, a, m, 1'($urandom), d);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule